// File: doc/BRIEF.md
# Internal Profile Sequencer

The sequencer decides which of four waveform profiles drives the RAM address generator. While it is idle the profile follows the two external select pins. When a nonzero control code is programmed and RAM playback is enabled, it ignores the pins and steps through profiles itself. It advances each time the address generator reports that the current profile's segment has reached its final address. The result is a composite sweep built from consecutive RAM segments.

Bit 2 of the 3-bit control code selects looping instead of a single pass. The low bits set how many profiles take part, from two to four. A single-pass run stops on its last profile and raises a completion flag. A looping run returns to profile 0 and keeps going. An update strobe restarts the sequence from profile 0. While the sequencer is in control, it tells the address generator to treat every profile as a ramp-up segment, whatever that profile's own mode field says.

Top module: `profile_seq`

## Requirements
- R1: With control code 000 the profile output equals the external pins in the same cycle, and force-ramp-up and the completion flag are low.
- R2: Control code 111 behaves exactly as code 000.
- R3: Codes 001, 010 and 011 run one pass over profiles 0..1, 0..2 and 0..3. After the segment-done that ends the last profile, the output holds that last profile and the completion flag goes high.
- R4: Codes 100, 101 and 110 loop over profiles 0..1, 0..2 and 0..3. A segment-done on the last profile returns the output to 0, and the completion flag never goes high.
- R5: While the sequencer is in control, each segment-done pulse advances the profile by exactly one, and the new value appears on the output one clock later. The profile does not change when there is no pulse.
- R6: Force-ramp-up is high exactly when RAM mode is on and the code is 001 to 110.
- R7: With RAM mode off, the output follows the external pins, force-ramp-up is low, and the internal state returns to profile 0 with the flag cleared. Turning RAM mode back on therefore starts from profile 0.
- R8: An update strobe sets the profile to 0 and clears the completion flag on the next clock.
- R9: Once a single pass has completed, further segment-done pulses have no effect on the profile or the flag.
- R10: When an update strobe and a segment-done pulse arrive in the same cycle, the update wins and the result is profile 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 3 | Sequencing control code |
| ram_mode_i | input | 1 | RAM playback enabled |
| update_i | input | 1 | Update strobe, one cycle |
| ext_profile_i | input | 2 | External profile select pins |
| seg_done_i | input | 1 | Address generator reached segment final address |
| profile_o | output | 2 | Active profile |
| force_ramp_o | output | 1 | Force ramp-up mode in the address generator |
| seq_done_o | output | 1 | Single pass finished |

## Verification
The pass-through path and force-ramp-up are combinational, so the bench checks them in the same cycle it drives the inputs. A segment-done or update pulse reaches the output through a single state register, so its effect is due one clock after the edge that samples it. The bench drives inputs just after the falling edge and samples one full cycle later, at the next falling edge. For every code it computes the expected profile from the pulse count: the count clamped to the last profile in single-pass mode, or taken modulo the number of profiles in looping mode.

// File: rtl/profile_seq_pkg.sv
package profile_seq_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned PROF_W = 2;

  typedef struct packed {
    logic              active;
    logic              loop;
    logic [PROF_W-1:0] last;
  } seq_cfg_t;
endpackage

// File: rtl/profile_seq_decode.sv
module profile_seq_decode
  import profile_seq_pkg::*;
(
  input  logic [CODE_W-1:0] ctrl_i,
  input  logic              ram_mode_i,
  output seq_cfg_t          cfg_o
);
  logic code_valid;
  assign code_valid = (ctrl_i != '0) && (ctrl_i != '1);

  always_comb begin
    cfg_o.active = ram_mode_i && code_valid;
    cfg_o.loop   = ctrl_i[2];
    // loop codes are offset by one: 100 -> last profile 1
    cfg_o.last   = ctrl_i[2] ? PROF_W'(ctrl_i[1:0] + 2'd1) : PROF_W'(ctrl_i[1:0]);
  end
endmodule

// File: rtl/profile_seq_fsm.sv
module profile_seq_fsm
  import profile_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ram_mode_i,
  input  seq_cfg_t          cfg_i,
  input  logic              update_i,
  input  logic              seg_done_i,
  output logic [PROF_W-1:0] cur_o,
  output logic              done_o
);
  logic [PROF_W-1:0] cur_q;
  logic              done_q;
  logic              at_last;

  assign at_last = (cur_q >= cfg_i.last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      done_q <= 1'b0;
    end else if (!ram_mode_i || !cfg_i.active || update_i) begin
      cur_q  <= '0;
      done_q <= 1'b0;
    end else if (seg_done_i && !done_q) begin
      if (!at_last)        cur_q  <= cur_q + PROF_W'(1);
      else if (cfg_i.loop) cur_q  <= '0;
      else                 done_q <= 1'b1;
    end
  end

  assign cur_o  = cur_q;
  assign done_o = done_q;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.active && seg_done_i && !update_i && !done_q && !at_last)
      |=> (cur_q == $past(cur_q) + PROF_W'(1))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.active && !seg_done_i && !update_i) |=> $stable(cur_q)); // R5
  AST_LOOP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.active && cfg_i.loop && seg_done_i && !update_i && at_last)
      |=> (cur_q == '0)); // R4
  AST_LOOP_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.active && cfg_i.loop && !done_q) |=> !done_q); // R4
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && cfg_i.active && !update_i && $stable(cfg_i))
      |=> (done_q && $stable(cur_q))); // R9
  AST_UPDATE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (cur_q == '0 && !done_q)); // R8 R10
  AST_RAM_OFF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_mode_i |=> (cur_q == '0 && !done_q)); // R7
endmodule

// File: rtl/profile_seq.sv
module profile_seq
  import profile_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] ctrl_i,
  input  logic              ram_mode_i,
  input  logic              update_i,
  input  logic [PROF_W-1:0] ext_profile_i,
  input  logic              seg_done_i,
  output logic [PROF_W-1:0] profile_o,
  output logic              force_ramp_o,
  output logic              seq_done_o
);
  seq_cfg_t          cfg;
  logic [PROF_W-1:0] cur;
  logic              done;

  profile_seq_decode u_decode (
    .ctrl_i     (ctrl_i),
    .ram_mode_i (ram_mode_i),
    .cfg_o      (cfg)
  );

  profile_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ram_mode_i (ram_mode_i),
    .cfg_i      (cfg),
    .update_i   (update_i),
    .seg_done_i (seg_done_i),
    .cur_o      (cur),
    .done_o     (done)
  );

  assign profile_o    = cfg.active ? cur : ext_profile_i;
  assign force_ramp_o = cfg.active;
  assign seq_done_o   = cfg.active && done;

  AST_INACTIVE_PINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_mode_i || ctrl_i == 3'b000 || ctrl_i == 3'b111)
      |-> (profile_o == ext_profile_i && !force_ramp_o && !seq_done_o)); // R1 R2 R7
  AST_DONE_AT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done_o |-> (!ctrl_i[2] && profile_o == ctrl_i[1:0])); // R3
endmodule

// File: tb/profile_seq_tb.sv
module profile_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ctrl = 3'd0;
  logic       ram = 1'b0;
  logic       upd = 1'b0;
  logic [1:0] ext = 2'd0;
  logic       seg = 1'b0;
  logic [1:0] prof;
  logic       frc;
  logic       sdone;
  int         errors = 0;
  int         checks = 0;
  bit         fin = 1'b0;

  always #4 clk = ~clk;

  profile_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .ram_mode_i(ram),
    .update_i(upd), .ext_profile_i(ext), .seg_done_i(seg),
    .profile_o(prof), .force_ramp_o(frc), .seq_done_o(sdone)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle with given pulses; samples at the next falling edge
  task automatic cyc(input logic u, input logic s);
    upd = u; seg = s;
    @(negedge clk);
    upd = 1'b0; seg = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // reset state (RAM off -> pins through)
    ext = 2'd2;
    #1 chk("R7 reset prof", prof, 2);
    chk("R7 reset force", frc, 0);
    chk("R7 reset done", sdone, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // codes 0 and 7: pass-through, pulses ignored
    ram = 1'b1;
    for (int c = 0; c < 2; c++) begin
      ctrl = (c == 0) ? 3'd0 : 3'd7;
      for (int p = 0; p < 4; p++) begin
        ext = p[1:0];
        cyc(1'b0, 1'b1);
        chk(c == 0 ? "R1 pins" : "R2 pins", prof, p);
        chk(c == 0 ? "R1 force" : "R2 force", frc, 0);
        chk(c == 0 ? "R1 done" : "R2 done", sdone, 0);
      end
    end

    // active codes: sweep pulse counts
    ext = 2'd3;
    for (int c = 1; c <= 6; c++) begin
      int last;
      bit lp;
      lp = (c >= 4);
      last = lp ? c - 3 : c;
      ctrl = c[2:0];
      cyc(1'b1, 1'b0);
      chk("R8 start prof", prof, 0);
      chk("R6 force", frc, 1);
      chk("R8 start done", sdone, 0);
      for (int k = 1; k <= 10; k++) begin
        int ep, ed;
        cyc(1'b0, 1'b1);
        if (lp) begin ep = k % (last + 1); ed = 0; end
        else begin ep = (k < last) ? k : last; ed = (k > last) ? 1 : 0; end
        chk(lp ? "R4 prof" : (k > last + 1 ? "R9 prof" : "R3 prof"), prof, ep);
        chk(lp ? "R4 done" : (k > last + 1 ? "R9 done" : "R3 done"), sdone, ed);
        cyc(1'b0, 1'b0);
        chk("R5 hold", prof, ep);
      end
      // restart after burst / mid loop
      cyc(1'b1, 1'b0);
      chk("R8 restart prof", prof, 0);
      chk("R8 restart done", sdone, 0);
      cyc(1'b0, 1'b1);
      chk("R5 first step", prof, 1);
      // simultaneous update and segment done
      cyc(1'b1, 1'b1);
      chk("R10 prio", prof, 0);
    end

    // RAM mode off mid-sequence
    ctrl = 3'd6;
    cyc(1'b1, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);
    chk("R5 at two", prof, 2);
    ram = 1'b0; ext = 2'd1;
    #1 chk("R7 pins", prof, 1);
    chk("R7 force", frc, 0);
    @(negedge clk);
    ram = 1'b1;
    #1 chk("R7 back at 0", prof, 0);
    chk("R6 force back", frc, 1);
    @(negedge clk);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule